// File: doc/BRIEF.md
# OUT Endpoint Interrupt Aggregator

This block collects interrupt events for a set of OUT endpoints of a USB device controller and keeps them as sticky status flags, one status word per endpoint. The endpoint logic delivers single-cycle event pulses:

- transfer complete
- endpoint disabled on request
- SETUP stage done
- OUT token arrived while the endpoint was off
- NYET handshake sent
- a SETUP packet or any other packet received

Software reads each endpoint's word through a small register port and clears flags by writing ones.

A per-endpoint counter watches runs of consecutive SETUP packets on control endpoints. It flags a run that grows past three packets.

The per-endpoint words are folded into an endpoint summary vector, one bit per endpoint. The summary is also readable at its own address. A single OUT-endpoint interrupt line is the OR of the summary. Clearing an endpoint's last pending flag therefore drops its summary bit and, once no endpoint is pending, the interrupt line.

Top module: `oepi_aggregator`

## Requirements
- R1: After reset every endpoint word reads 0x0000_0080, `ep_summary` is 0 and `out_irq` is 0.
- R2: The word of endpoint n (n = 0..NUM_EP-1) sits at address 0xB08 + n*0x20. A read strobe returns data on `reg_rdata` one clock later. Any other address except the summary address reads 0, and writes to it change nothing.
- R3: A pulse on `ev_xfer_done[n]`, `ev_ep_disabled[n]` or `ev_nyet_sent[n]` sets bit 0, bit 1 or bit 14 of endpoint n's word. The bit stays set until software clears it.
- R4: A pulse on `ev_setup_done[n]` sets bit 3, and a pulse on `ev_out_while_off[n]` sets bit 4, only when endpoint n is a control endpoint (bit n of CTRL_EP_MASK, default 0x01). On other endpoints these pulses leave the word unchanged.
- R5: Writing a 1 to a defined bit (0, 1, 3, 4, 6, 14) clears it. Writing a 0 leaves it unchanged.
- R6: If an event arrives in the same cycle as a write-1 clear of its bit, the bit remains set.
- R7: Reserved bits (31:15, 13:7, 5, 2) always read their reset value. Writes to them are ignored.
- R8: On a control endpoint, bit 6 is set by the fourth SETUP packet in a row, and by every further one. A packet that is not SETUP restarts the count. The count saturates at four. Bit 6 never sets on other endpoints.
- R9: `ep_summary[n]` is the OR of endpoint n's defined bits and follows the status one cycle later. The same vector reads at address 0x800 in bits [NUM_EP-1:0]. `out_irq` is the OR of `ep_summary`.
- R10: Clearing the last pending bit of every endpoint returns `ep_summary` and `out_irq` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_xfer_done | input | NUM_EP | Transfer-complete pulse per endpoint |
| ev_ep_disabled | input | NUM_EP | Endpoint-disabled pulse per endpoint |
| ev_setup_done | input | NUM_EP | SETUP stage done pulse per endpoint |
| ev_out_while_off | input | NUM_EP | OUT token while endpoint off, per endpoint |
| ev_nyet_sent | input | NUM_EP | NYET handshake sent, per endpoint |
| ev_setup_pkt | input | NUM_EP | SETUP packet received, per endpoint |
| ev_other_pkt | input | NUM_EP | Non-SETUP token or data packet received, per endpoint |
| reg_wr_en | input | 1 | Register write strobe (write-1-to-clear) |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| ep_summary | output | NUM_EP | Registered per-endpoint pending summary |
| out_irq | output | 1 | Registered global OUT-endpoint interrupt |

## Verification
The assertions assume that an endpoint never reports a SETUP packet and a non-SETUP packet in the same cycle, since the counter gives such a pair no meaning. They also assume that each event input is a clean single-cycle pulse, sampled on the clock. The bench drives every event from a task that raises exactly one bit for exactly one cycle. The only deliberate overlap it creates is an event that lands on the same edge as a register write, which is the collision case.

// File: rtl/oepi_pkg.sv
package oepi_pkg;

  // Defined flags of one endpoint word; bit positions are decoded by software.
  typedef struct packed {
    logic nyet;    // bit 14
    logic b2b;     // bit 6
    logic offtok;  // bit 4
    logic stdone;  // bit 3
    logic epdis;   // bit 1
    logic xfer;    // bit 0
  } ep_flags_t;

  localparam int POS_XFER   = 0;
  localparam int POS_EPDIS  = 1;
  localparam int POS_STDONE = 3;
  localparam int POS_OFFTOK = 4;
  localparam int POS_B2B    = 6;
  localparam int POS_NYET   = 14;

  localparam logic [31:0] WORD_RESET = 32'h0000_0080;

  function automatic logic [31:0] flags_to_word(input ep_flags_t f);
    logic [31:0] w;
    w = WORD_RESET;
    w[POS_XFER]   = f.xfer;
    w[POS_EPDIS]  = f.epdis;
    w[POS_STDONE] = f.stdone;
    w[POS_OFFTOK] = f.offtok;
    w[POS_B2B]    = f.b2b;
    w[POS_NYET]   = f.nyet;
    return w;
  endfunction

  function automatic ep_flags_t word_to_flags(input logic [31:0] w);
    ep_flags_t f;
    f.xfer   = w[POS_XFER];
    f.epdis  = w[POS_EPDIS];
    f.stdone = w[POS_STDONE];
    f.offtok = w[POS_OFFTOK];
    f.b2b    = w[POS_B2B];
    f.nyet   = w[POS_NYET];
    return f;
  endfunction

endpackage

// File: rtl/oepi_b2b_counter.sv
module oepi_b2b_counter #(
  parameter int LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic setup_pkt,
  input  logic other_pkt,
  output logic over_limit
);
  localparam int SAT   = LIMIT + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (other_pkt) begin
      cnt_q <= '0;
    end else if (setup_pkt && cnt_q != SAT_V) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Current packet is the (LIMIT+1)-th or later SETUP in a row
  assign over_limit = setup_pkt && (cnt_q >= LIM_V);

  // R8
  no_pkt_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(setup_pkt && other_pkt));

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= SAT_V);

  // R8
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    other_pkt |=> cnt_q == '0);

endmodule

// File: rtl/oepi_ep_status.sv
module oepi_ep_status
  import oepi_pkg::*;
#(
  parameter bit IS_CTRL   = 1'b0,
  parameter int B2B_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_xfer,
  input  logic      ev_epdis,
  input  logic      ev_stdone,
  input  logic      ev_offtok,
  input  logic      ev_nyet,
  input  logic      ev_setup_pkt,
  input  logic      ev_other_pkt,
  input  logic      clr_en,
  input  ep_flags_t clr_mask,
  output ep_flags_t flags,
  output logic      pending
);
  ep_flags_t flags_q, set_v, clr_v;
  logic      b2b_hit;

  generate
    if (IS_CTRL) begin : g_ctrl
      oepi_b2b_counter #(.LIMIT(B2B_LIMIT)) u_b2b (
        .clk        (clk),
        .rst        (rst),
        .setup_pkt  (ev_setup_pkt),
        .other_pkt  (ev_other_pkt),
        .over_limit (b2b_hit)
      );
    end else begin : g_plain
      assign b2b_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    set_v.xfer   = ev_xfer;
    set_v.epdis  = ev_epdis;
    set_v.nyet   = ev_nyet;
    set_v.stdone = IS_CTRL && ev_stdone;
    set_v.offtok = IS_CTRL && ev_offtok;
    set_v.b2b    = b2b_hit;
    clr_v        = clr_en ? clr_mask : '0;
  end

  // Event wins over a simultaneous write-1 clear
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_v) | set_v;
  end

  assign flags   = flags_q;
  assign pending = |flags_q;

  // R3
  xfer_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ev_xfer |=> flags_q.xfer);

  // R3
  hold_until_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flags_q.nyet && !(clr_en && clr_mask.nyet)) |=> flags_q.nyet);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_mask.epdis && !ev_epdis) |=> !flags_q.epdis);

  // R6
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_en && clr_mask.xfer && ev_xfer) |=> flags_q.xfer);

endmodule

// File: rtl/oepi_reg_port.sv
module oepi_reg_port
  import oepi_pkg::*;
#(
  parameter int               NUM_EP   = 8,
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] BASE    = 12'hB08,
  parameter int               STRIDE   = 32,
  parameter logic [ADDR_W-1:0] SUM_ADDR = 12'h800
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [NUM_EP-1:0][DATA_W-1:0] words,
  input  logic [NUM_EP-1:0]             summary,
  output logic [NUM_EP-1:0]             wr_sel,
  output ep_flags_t                     clr_mask,
  output logic [DATA_W-1:0]             rdata
);
  localparam int SH    = $clog2(STRIDE);
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [ADDR_W-1:0] EP_LIM = ADDR_W'(NUM_EP);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    off  = addr - BASE;
    slot = off >> SH;
    hit  = (addr >= BASE) && (off[SH-1:0] == '0) && (slot < EP_LIM);
    idx  = slot[IDX_W-1:0];
    for (int i = 0; i < NUM_EP; i++) begin
      wr_sel[i] = wr_en && hit && (idx == IDX_W'(i));
    end
    clr_mask = word_to_flags(wdata[31:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (hit)                   rdata <= words[idx];
      else if (addr == SUM_ADDR) rdata <= DATA_W'(summary);
      else                       rdata <= '0;
    end
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_sel));

endmodule

// File: rtl/oepi_aggregator.sv
module oepi_aggregator
  import oepi_pkg::*;
#(
  parameter int                NUM_EP      = 8,
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter logic [ADDR_W-1:0] BASE        = 12'hB08,
  parameter int                STRIDE      = 32,
  parameter logic [ADDR_W-1:0] SUM_ADDR    = 12'h800,
  parameter logic [NUM_EP-1:0] CTRL_EP_MASK = 8'h01,
  parameter int                B2B_LIMIT   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] ev_xfer_done,
  input  logic [NUM_EP-1:0] ev_ep_disabled,
  input  logic [NUM_EP-1:0] ev_setup_done,
  input  logic [NUM_EP-1:0] ev_out_while_off,
  input  logic [NUM_EP-1:0] ev_nyet_sent,
  input  logic [NUM_EP-1:0] ev_setup_pkt,
  input  logic [NUM_EP-1:0] ev_other_pkt,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NUM_EP-1:0] ep_summary,
  output logic              out_irq
);
  logic [NUM_EP-1:0]             wr_sel;
  ep_flags_t                     clr_mask;
  ep_flags_t [NUM_EP-1:0]        flags;
  logic [NUM_EP-1:0]             pend;
  logic [NUM_EP-1:0][DATA_W-1:0] words;

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_ep
      oepi_ep_status #(
        .IS_CTRL   (CTRL_EP_MASK[g]),
        .B2B_LIMIT (B2B_LIMIT)
      ) u_ep (
        .clk          (clk),
        .rst          (rst),
        .ev_xfer      (ev_xfer_done[g]),
        .ev_epdis     (ev_ep_disabled[g]),
        .ev_stdone    (ev_setup_done[g]),
        .ev_offtok    (ev_out_while_off[g]),
        .ev_nyet      (ev_nyet_sent[g]),
        .ev_setup_pkt (ev_setup_pkt[g]),
        .ev_other_pkt (ev_other_pkt[g]),
        .clr_en       (wr_sel[g]),
        .clr_mask     (clr_mask),
        .flags        (flags[g]),
        .pending      (pend[g])
      );
      assign words[g] = DATA_W'(flags_to_word(flags[g]));
    end
  endgenerate

  oepi_reg_port #(
    .NUM_EP   (NUM_EP),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE     (BASE),
    .STRIDE   (STRIDE),
    .SUM_ADDR (SUM_ADDR)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .rd_en    (reg_rd_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .words    (words),
    .summary  (ep_summary),
    .wr_sel   (wr_sel),
    .clr_mask (clr_mask),
    .rdata    (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ep_summary <= '0;
      out_irq    <= 1'b0;
    end else begin
      ep_summary <= pend;
      out_irq    <= |pend;
    end
  end

  // R9
  irq_summary_chk: assert property (@(posedge clk) disable iff (rst)
    out_irq == (ep_summary != '0));

  // R10
  summary_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !out_irq);

endmodule

// File: tb/tb_oepi_aggregator.sv
module tb_oepi_aggregator;
  localparam int NEP = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NEP-1:0] ev_xfer_done = '0, ev_ep_disabled = '0, ev_setup_done = '0;
  logic [NEP-1:0] ev_out_while_off = '0, ev_nyet_sent = '0;
  logic [NEP-1:0] ev_setup_pkt = '0, ev_other_pkt = '0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NEP-1:0] ep_summary;
  logic        out_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  oepi_aggregator dut (
    .clk(clk), .rst(rst),
    .ev_xfer_done(ev_xfer_done), .ev_ep_disabled(ev_ep_disabled),
    .ev_setup_done(ev_setup_done), .ev_out_while_off(ev_out_while_off),
    .ev_nyet_sent(ev_nyet_sent), .ev_setup_pkt(ev_setup_pkt),
    .ev_other_pkt(ev_other_pkt),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ep_summary(ep_summary), .out_irq(out_irq)
  );

  function automatic logic [11:0] ep_addr(input int n);
    return 12'(12'hB08 + n * 32);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // kind: 0 xfer, 1 epdis, 2 setup done, 3 off token, 4 nyet, 5 setup pkt, 6 other pkt
  task automatic pulse(input int kind, input int ep);
    @(negedge clk);
    case (kind)
      0: ev_xfer_done[ep] = 1'b1;
      1: ev_ep_disabled[ep] = 1'b1;
      2: ev_setup_done[ep] = 1'b1;
      3: ev_out_while_off[ep] = 1'b1;
      4: ev_nyet_sent[ep] = 1'b1;
      5: ev_setup_pkt[ep] = 1'b1;
      default: ev_other_pkt[ep] = 1'b1;
    endcase
    @(negedge clk);
    ev_xfer_done = '0; ev_ep_disabled = '0; ev_setup_done = '0;
    ev_out_while_off = '0; ev_nyet_sent = '0; ev_setup_pkt = '0; ev_other_pkt = '0;
  endtask

  task automatic clear_all();
    for (int n = 0; n < NEP; n++) wr(ep_addr(n), 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int n = 0; n < NEP; n++) begin
      rd(ep_addr(n), d);
      check("R1 reset word", d, 32'h80);
    end
    check("R1 summary", 32'(ep_summary), 0);
    check("R1 irq", 32'(out_irq), 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(0, 2); pulse(1, 5); pulse(4, 7);
    repeat (3) @(negedge clk);
    rd(ep_addr(2), d); check("R3 xfer bit0 ep2", d, 32'h81);
    rd(ep_addr(5), d); check("R3 epdis bit1 ep5", d, 32'h82);
    rd(ep_addr(7), d); check("R3 nyet bit14 ep7", d, 32'h4080);
    rd(ep_addr(2), d); check("R3 sticky ep2", d, 32'h81);
    check("R9 summary", 32'(ep_summary), 32'hA4);
    check("R9 irq", 32'(out_irq), 1);
    rd(12'h800, d); check("R9 summary addr", d, 32'hA4);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(0, 4); pulse(4, 4);
    wr(ep_addr(4), 32'h0000_0000);
    rd(ep_addr(4), d); check("R5 write zero keeps", d, 32'h4081);
    wr(ep_addr(4), 32'h0000_4000);
    rd(ep_addr(4), d); check("R5 write one clears", d, 32'h81);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = ep_addr(4); reg_wdata = 32'h1;
    ev_xfer_done[4] = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; ev_xfer_done = '0;
    rd(ep_addr(4), d); check("R6 event wins", d, 32'h81);
  endtask

  task automatic t_ctrl_only();
    logic [31:0] d;
    pulse(2, 0); pulse(3, 0);
    rd(ep_addr(0), d); check("R4 ctrl ep0 bits3,4", d, 32'h98);
    pulse(2, 3); pulse(3, 3);
    rd(ep_addr(3), d); check("R4 non-ctrl ep3 ignored", d, 32'h80);
  endtask

  task automatic t_reserved_map();
    logic [31:0] d;
    wr(ep_addr(6), 32'hFFFF_BFFF);
    rd(ep_addr(6), d); check("R7 reserved write ignored", d, 32'h80);
    pulse(0, 6);
    wr(ep_addr(6), 32'h0000_0000);
    rd(ep_addr(6), d); check("R7 bit7 holds", d, 32'h81);
    wr(12'hB0C, 32'hFFFF_FFFF);
    rd(ep_addr(0), d); check("R2 unmapped write no effect", d, 32'h98);
    rd(12'hB0C, d); check("R2 unaligned reads zero", d, 0);
    rd(12'hC08, d); check("R2 beyond last ep reads zero", d, 0);
    wr(ep_addr(6), 32'h1);
    rd(ep_addr(6), d); check("R2 ep6 address", d, 32'h80);
  endtask

  task automatic t_b2b();
    logic [31:0] d;
    clear_all();
    repeat (3) pulse(5, 0);
    rd(ep_addr(0), d); check("R8 three setups no flag", d, 32'h80);
    pulse(5, 0);
    rd(ep_addr(0), d); check("R8 fourth setup flags", d, 32'hC0);
    wr(ep_addr(0), 32'h40);
    repeat (2) pulse(5, 0);
    rd(ep_addr(0), d); check("R8 saturated run still flags", d, 32'hC0);
    wr(ep_addr(0), 32'h40);
    pulse(6, 0);
    repeat (3) pulse(5, 0);
    rd(ep_addr(0), d); check("R8 other pkt restarts", d, 32'h80);
    pulse(5, 0);
    rd(ep_addr(0), d); check("R8 fourth after restart", d, 32'hC0);
    repeat (6) pulse(5, 3);
    rd(ep_addr(3), d); check("R8 non-ctrl no flag", d, 32'h80);
  endtask

  task automatic t_drop();
    clear_all();
    check("R10 summary zero", 32'(ep_summary), 0);
    check("R10 irq low", 32'(out_irq), 0);
    pulse(1, 1);
    @(negedge clk);
    check("R9 summary bit1", 32'(ep_summary), 32'h2);
    wr(ep_addr(1), 32'h2);
    @(negedge clk);
    check("R10 irq drops", 32'(out_irq), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_clear();
    t_collision();
    t_ctrl_only();
    t_reserved_map();
    t_b2b();
    t_drop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule